// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous request port and an external asynchronous static RAM of 131072 words by 16 bits. A client offers one word access at a time with a valid/ready handshake: a direction bit, a 17-bit word address, write data and a per-byte lane mask. The controller turns each request into a strobe sequence for the memory: chip selects, output enable, write enable and the two active-low byte-lane enables. It also drives a split data bus made of an output word, an output-enable flag and an input word. When the access is complete it raises `done` for one cycle, and on a read it presents the sampled word on `rd_data`.

Every phase length is derived at elaboration from nanosecond limits and the clock period in picoseconds. A phase lasts the ceiling of the limit divided by the period. The read access window adds one extra cycle so that the sample point lies after the access time. At 200 MHz this gives 8 write-enable-low cycles, 12 read-window cycles and an 11-cycle minimum write cycle. Output enable is held high for the whole of every write, so the write-enable-to-high-Z restriction never applies.

The control is one state machine with six states. IDLE goes to W_SETUP when it accepts a write with at least one lane. IDLE goes to R_ACCESS when it accepts such a read. IDLE stays in IDLE and completes at once when it accepts a request with no lane. W_SETUP goes to W_PULSE after one cycle. W_PULSE goes to W_HOLD when the pulse count expires. W_HOLD goes to RECOVER if the write cycle needs padding, and otherwise to IDLE. R_ACCESS goes to IDLE when its window expires. RECOVER goes to IDLE when the padding expires.

Top module: `asram_ctrl`

## Requirements
- R1: From reset and whenever `req_ready` is high, the memory is deselected (`mem_cs_n`=1, `mem_cs_hi`=0), `mem_we_n`=1, `mem_oe_n`=1, both `mem_lane_n` bits are 1 and `mem_dq_oe`=0.
- R2: `req_ready` is low from the cycle after a request with a lane is accepted until that request's `done` cycle, and it is high in the `done` cycle itself, so a new request can be accepted in that cycle.
- R3: A write starts with one cycle selected, with data driven and write enable high. Write enable is then low for exactly WP cycles, where WP is the largest of ceil(40 ns/Tclk), ceil(28 ns/Tclk) and ceil(40 ns/Tclk)−1 (8 at 5 ns). After that comes one cycle still selected with data driven and write enable high, and then the data bus is released.
- R4: `mem_oe_n` is 1 in every cycle in which `mem_we_n` is 0.
- R5: `mem_dq_out` is unchanged and `mem_dq_oe` is 1 in every cycle in which `mem_we_n` is 0.
- R6: Two successive chip-select assertions start at least ceil(55 ns/Tclk) cycles apart (11 at 5 ns).
- R7: `req_be` bit 0 enables the lower lane (data bits 7..0, `mem_lane_n[0]` low) and bit 1 enables the upper lane (bits 15..8, `mem_lane_n[1]` low). A write changes only the enabled lanes of the addressed word.
- R8: A read holds the memory selected with `mem_oe_n`=0 and `mem_we_n`=1 for exactly ceil(55 ns/Tclk)+1 cycles (12 at 5 ns). It samples `mem_dq_in` on the last of them and shows the word on `rd_data` in the following cycle, which is the `done` cycle.
- R9: In a read result, a byte lane that was not requested reads as 8'h00, whatever the memory drives on it.
- R10: A request with `req_be`=0 is accepted, never selects the memory, and raises `done` in the next cycle with `req_ready` still high. A read of this kind returns 16'h0000.
- R11: `mem_cs_hi` is always the complement of `mem_cs_n`, and the memory is selected only with at least one lane enable low.
- R12: Each accepted request produces exactly one `done` cycle, and results come back in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Active-high lane mask, bit 0 lower byte, bit 1 upper byte |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with `done` after a read |
| mem_addr | output | 17 | Memory word address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs_hi | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_lane_n | output | 2 | Active-low byte-lane enables, bit 0 lower, bit 1 upper |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | 1 = pad drives `mem_dq_out` |
| mem_dq_in | input | 16 | Data from the memory pads |

## Verification
The completion of one access and the acceptance of the next can fall in the same cycle: `done` is registered as the machine returns to IDLE, and `req_ready` rises in that same cycle. The bench provokes this with back-to-back streams of mixed writes and reads in which the driver offers the next request at the very edge on which `done` appears. The scoreboard then judges that every result comes back in order, that `req_ready` was high with `done`, and that the next chip-select assertion still respects the minimum cycle spacing. Requests with an empty lane mask complete in one cycle, so they also create adjacent `done` cycles without touching the memory.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACCESS,
        ST_RECOVER
    } ctl_state_e;

    // Whole clock cycles that cover a nanosecond limit, never less than one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
        int unsigned c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign last = (cnt == '0);

    // R3, R8: a running phase counts down by one each cycle
    a_r3_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

endmodule

// File: rtl/asram_lane_merge.sv
module asram_lane_merge #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   din,
    input  logic [DW/8-1:0] lane_en,
    output logic [DW-1:0]   dout
);
    localparam int LANES = DW / 8;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign dout[l*8 +: 8] = lane_en[l] ? din[l*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int AW        = 17,
    parameter int DW        = 16,
    parameter int CLK_PS    = 5000,
    parameter int T_WC_NS   = 55,
    parameter int T_PWE_NS  = 40,
    parameter int T_SD_NS   = 28,
    parameter int T_AW_NS   = 40,
    parameter int T_RC_NS   = 55,
    parameter int T_AA_NS   = 55,
    parameter int T_DOE_NS  = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [DW/8-1:0] req_be,
    output logic            done,
    output logic [DW-1:0]   rd_data,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_cs_n,
    output logic            mem_cs_hi,
    output logic            mem_oe_n,
    output logic            mem_we_n,
    output logic [DW/8-1:0] mem_lane_n,
    output logic [DW-1:0]   mem_dq_out,
    output logic            mem_dq_oe,
    input  logic [DW-1:0]   mem_dq_in
);
    localparam int LANES   = DW / 8;
    localparam int WP_CYC  = int'(max2(max2(ns_to_cyc(T_PWE_NS, CLK_PS), ns_to_cyc(T_SD_NS, CLK_PS)),
                                       ns_to_cyc(T_AW_NS, CLK_PS) - 1));
    localparam int WC_CYC  = int'(ns_to_cyc(T_WC_NS, CLK_PS));
    localparam int WR_SPAN = WP_CYC + 2;
    localparam int PAD_CYC = (WC_CYC > WR_SPAN) ? WC_CYC - WR_SPAN : 0;
    localparam int RD_CYC  = int'(max2(max2(ns_to_cyc(T_AA_NS, CLK_PS), ns_to_cyc(T_RC_NS, CLK_PS)),
                                       ns_to_cyc(T_DOE_NS, CLK_PS))) + 1;
    localparam int CW      = $clog2(max2(max2(WP_CYC, PAD_CYC), RD_CYC) + 1);

    ctl_state_e           state_q, state_d;
    logic                 accept, accept_any, phase_last, tmr_load;
    logic [CW-1:0]        tmr_val;
    logic [LANES-1:0]     be_q, be_d;
    logic [DW-1:0]        merged;

    assign req_ready  = (state_q == ST_IDLE);
    assign accept_any = req_valid && req_ready;
    assign accept     = accept_any && (req_be != '0);
    assign be_d       = accept ? req_be : be_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = req_write ? ST_WSETUP : ST_RACCESS;
            ST_WSETUP:  if (phase_last) state_d = ST_WPULSE;
            ST_WPULSE:  if (phase_last) state_d = ST_WHOLD;
            ST_WHOLD:   if (phase_last) state_d = (PAD_CYC > 0) ? ST_RECOVER : ST_IDLE;
            ST_RACCESS: if (phase_last) state_d = ST_IDLE;
            ST_RECOVER: if (phase_last) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // phase length loaded on every state change
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_WPULSE:  tmr_val = CW'(WP_CYC - 1);
            ST_RACCESS: tmr_val = CW'(RD_CYC - 1);
            ST_RECOVER: tmr_val = CW'((PAD_CYC > 0) ? PAD_CYC - 1 : 0);
            default:    tmr_val = '0;
        endcase
    end

    asram_phase_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (phase_last)
    );

    asram_lane_merge #(.DW(DW)) u_merge (
        .din     (mem_dq_in),
        .lane_en (be_q),
        .dout    (merged)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            be_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) be_q <= req_be;
        end
    end

    // strobes, registered from the next state so they switch cleanly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_cs_n   <= 1'b1;
            mem_cs_hi  <= 1'b0;
            mem_oe_n   <= 1'b1;
            mem_we_n   <= 1'b1;
            mem_lane_n <= '1;
            mem_dq_out <= '0;
            mem_dq_oe  <= 1'b0;
        end else begin
            mem_cs_n   <= 1'b1;
            mem_cs_hi  <= 1'b0;
            mem_oe_n   <= 1'b1;
            mem_we_n   <= 1'b1;
            mem_lane_n <= '1;
            mem_dq_oe  <= 1'b0;
            unique case (state_d)
                ST_WSETUP, ST_WHOLD: begin
                    mem_cs_n   <= 1'b0;
                    mem_cs_hi  <= 1'b1;
                    mem_lane_n <= ~be_d;
                    mem_dq_oe  <= 1'b1;
                end
                ST_WPULSE: begin
                    mem_cs_n   <= 1'b0;
                    mem_cs_hi  <= 1'b1;
                    mem_lane_n <= ~be_d;
                    mem_dq_oe  <= 1'b1;
                    mem_we_n   <= 1'b0;
                end
                ST_RACCESS: begin
                    mem_cs_n   <= 1'b0;
                    mem_cs_hi  <= 1'b1;
                    mem_lane_n <= ~be_d;
                    mem_oe_n   <= 1'b0;
                end
                default: ;
            endcase
            if (accept) begin
                mem_addr   <= req_addr;
                mem_dq_out <= req_wdata;
            end
        end
    end

    // completion and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= (accept_any && req_be == '0) ||
                    (state_q != ST_IDLE && state_d == ST_IDLE);
            if (state_q == ST_RACCESS && phase_last)
                rd_data <= merged;
            else if (accept_any && req_be == '0 && !req_write)
                rd_data <= '0;
        end
    end

    // write-enable low run length, for the pulse-width check
    logic [CW-1:0] we_lo_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            we_lo_cnt <= '0;
        else if (!mem_we_n)    we_lo_cnt <= we_lo_cnt + CW'(1);
        else                   we_lo_cnt <= '0;
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && (&mem_lane_n)));

    a_r2_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    a_r3_we_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_cnt == CW'(WP_CYC)));

    a_r3_hold_driven: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_cs_n));

    a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    a_r5_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_dq_oe && $stable(mem_dq_out)));

    a_r11_cs_pair: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_hi == !mem_cs_n);

    a_r11_lane_on_select: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !(&mem_lane_n));

endmodule

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;

    localparam int WP_EXP  = 8;
    localparam int RD_EXP  = 12;
    localparam int WC_EXP  = 11;
    localparam int VALID_AGE = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, done;
    logic [15:0] rd_data;
    logic [16:0] mem_addr;
    logic        mem_cs_n, mem_cs_hi, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0]  mem_lane_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'h5A5A;

    always #2.5 clk = ~clk;

    asram_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .done(done), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs_hi(mem_cs_hi),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    typedef struct { bit is_rd; logic [15:0] exp; string tag; } sb_t;
    sb_t sbq[$];
    logic [15:0] ref_mem [int];
    logic [15:0] dev_mem [int];
    int issued = 0, dones = 0, sel_count = 0, cyc = 0;

    // driver: called at a negative edge
    task automatic issue(input bit wr, input logic [16:0] a, input logic [1:0] be,
                         input logic [15:0] d, input string tag);
        sb_t it;
        logic [15:0] cur;
        while (!req_ready) @(negedge clk);
        cur = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
        it.is_rd = !wr;
        it.tag = tag;
        if (wr) begin
            if (be[0]) cur[7:0]  = d[7:0];
            if (be[1]) cur[15:8] = d[15:8];
            ref_mem[int'(a)] = cur;
            it.exp = '0;
        end else begin
            it.exp = {be[1] ? cur[15:8] : 8'h00, be[0] ? cur[7:0] : 8'h00};
        end
        sbq.push_back(it);
        issued++;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (be == 2'b00) begin
            chk(done == 1'b1, "R10 done next cycle", 32'(done), 1);
            chk(req_ready == 1'b1, "R10 ready stays high", 32'(req_ready), 1);
        end else begin
            chk(req_ready == 1'b0, "R2 busy after accept", 32'(req_ready), 0);
        end
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
    endtask

    // monitor, timing observer and memory model
    int  we_run = 0, oe_run = 0, last_start = 0;
    bit  have_start = 0, prev_we_n = 1, prev_oe_n = 1, prev_cs_n = 1;
    bit  wr_pend = 0;
    logic [16:0] wr_a, rd_a;
    logic [15:0] wr_d;
    logic [1:0]  wr_l;
    int  age = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                dones++;
                chk(req_ready == 1'b1, "R2 ready in done cycle", 32'(req_ready), 1);
                if (sbq.size() == 0) begin
                    chk(1'b0, "R12 done without request", 1, 0);
                end else begin
                    sb_t it;
                    it = sbq.pop_front();
                    if (it.is_rd)
                        chk(rd_data == it.exp, it.tag, 32'(rd_data), 32'(it.exp));
                end
            end
            if (!mem_we_n) begin
                we_run++;
                chk(mem_oe_n == 1'b1, "R4 oe high while we low", 32'(mem_oe_n), 1);
            end else if (!prev_we_n) begin
                chk(we_run == WP_EXP, "R3 we low length", 32'(we_run), WP_EXP);
                chk(mem_dq_oe && !mem_cs_n, "R3 hold cycle driven", 32'({mem_dq_oe, mem_cs_n}), 32'h2);
                we_run = 0;
            end
            if (!mem_oe_n) oe_run++;
            else if (!prev_oe_n) begin
                chk(oe_run == RD_EXP, "R8 read window length", 32'(oe_run), RD_EXP);
                oe_run = 0;
            end
            if (!mem_cs_n && prev_cs_n) begin
                sel_count++;
                chk(mem_cs_hi == 1'b1 && mem_lane_n != 2'b11, "R11 select pair and lane",
                    32'({mem_cs_hi, mem_lane_n}), 32'h4);
                if (have_start)
                    chk(cyc - last_start >= WC_EXP, "R6 select spacing", 32'(cyc - last_start), WC_EXP);
                have_start = 1;
                last_start = cyc;
            end
            prev_we_n = mem_we_n; prev_oe_n = mem_oe_n; prev_cs_n = mem_cs_n;
        end
        // memory model: a write lands when the four-strobe overlap ends
        if (!mem_cs_n && mem_cs_hi && mem_lane_n != 2'b11 && !mem_we_n) begin
            wr_pend = 1; wr_a = mem_addr; wr_d = mem_dq_out; wr_l = ~mem_lane_n;
        end else if (wr_pend) begin
            logic [15:0] c;
            c = dev_mem.exists(int'(wr_a)) ? dev_mem[int'(wr_a)] : 16'h0000;
            if (wr_l[0]) c[7:0]  = wr_d[7:0];
            if (wr_l[1]) c[15:8] = wr_d[15:8];
            dev_mem[int'(wr_a)] = c;
            wr_pend = 0;
        end
        if (!mem_cs_n && mem_cs_hi && mem_we_n && !mem_oe_n && mem_lane_n != 2'b11) begin
            if (age != 0 && rd_a == mem_addr) age++;
            else begin age = 1; rd_a = mem_addr; end
        end else age = 0;
        if (age >= VALID_AGE) begin
            logic [15:0] v;
            v = dev_mem.exists(int'(rd_a)) ? dev_mem[int'(rd_a)] : 16'h0000;
            mem_dq_in = {mem_lane_n[1] ? 8'hC3 : v[15:8], mem_lane_n[0] ? 8'hC3 : v[7:0]};
        end else begin
            mem_dq_in = 16'h5A5A;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 50000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int sc;
        repeat (4) @(negedge clk);
        chk(mem_cs_n && !mem_cs_hi && mem_we_n && mem_oe_n && !mem_dq_oe && mem_lane_n == 2'b11,
            "R1 reset idle", 32'({mem_cs_n, mem_cs_hi, mem_we_n, mem_oe_n, mem_dq_oe}), 32'h16);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0, "R1 ready after reset", 32'({req_ready, done}), 32'h2);

        // R3 R7 R8: full word write and readback, at both ends of the address range
        issue(1, 17'h00010, 2'b11, 16'h1234, "R7");
        issue(0, 17'h00010, 2'b11, 16'h0000, "R8 full read");
        issue(1, 17'h1FFFF, 2'b11, 16'hBEEF, "R7");
        issue(1, 17'h00000, 2'b11, 16'hC0DE, "R7");
        issue(0, 17'h1FFFF, 2'b11, 16'h0000, "R8 top address");
        issue(0, 17'h00000, 2'b11, 16'h0000, "R8 bottom address");
        // R7: single-lane writes merge into the stored word
        issue(1, 17'h00010, 2'b01, 16'hAA55, "R7");
        issue(1, 17'h00010, 2'b10, 16'h77EE, "R7");
        issue(0, 17'h00010, 2'b11, 16'h0000, "R7 lane merge read");
        // R9: unrequested lanes read as zero
        issue(0, 17'h00010, 2'b01, 16'h0000, "R9 lower lane only");
        issue(0, 17'h00010, 2'b10, 16'h0000, "R9 upper lane only");
        drain();
        // R10: empty lane mask never selects the memory
        sc = sel_count;
        issue(1, 17'h00010, 2'b00, 16'hFFFF, "R10");
        issue(0, 17'h00010, 2'b00, 16'hFFFF, "R10 empty read zero");
        drain();
        chk(sel_count == sc, "R10 no select", 32'(sel_count), 32'(sc));
        issue(0, 17'h00010, 2'b11, 16'h0000, "R10 word untouched");
        // R2 R12: back-to-back mixed stream
        for (int i = 0; i < 8; i++)
            issue(1, 17'(i * 4099 + 3), 2'b11, 16'(i * 16'h1111 + 16'h0F0F), "R12");
        for (int i = 0; i < 8; i++) begin
            issue(0, 17'(i * 4099 + 3), 2'(i % 3 + 1), 16'h0000, "R12 stream read");
            issue(1, 17'(i * 4099 + 3), 2'b01, 16'(i), "R12");
            issue(0, 17'(i * 4099 + 3), 2'b11, 16'h0000, "R12 stream reread");
        end
        drain();
        repeat (20) @(negedge clk);
        chk(dones == issued, "R12 one done per request", 32'(dones), 32'(issued));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule